// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects a set of level-sensitive interrupt request lines into a pending register and drives two processor interrupt outputs: a normal request line and a fast request line. Each source has an enable bit, where a 0 enables the source and a 1 disables it, and a routing bit that sends the source to either output. For each output a fixed-priority resolver picks the highest-numbered source that is pending, enabled and routed to that output. It presents that source's index, so software can form a vector number from it directly.

Software reaches the block over a plain 32-bit register bus with byte address, write strobe, write data and combinational read data. Pending bits are cleared by writing ones to the pending register. A source input that is still asserted sets its bit again, so a request is never lost. The default configuration has 21 sources.

Top module: `prio_intc`

## Requirements
- R1: After reset the enable register (word offset 0x00) reads 0x001FFFFF, so every source is disabled. The routing register (0x04) and the pending register (0x08) read 0, and both outputs are low.
- R2: A write to 0x00 stores bits 20:0 as per-source disables, where 1 disables and 0 enables. A write to 0x04 stores bits 20:0 as routing, where 1 selects the fast output and 0 the normal output. Both registers read back what was stored.
- R3: An asserted source input sets its pending bit at the next clock edge even when the source is disabled. A disabled source affects neither output until it is enabled. No pending bit becomes set without its input having been asserted.
- R4: Writing to 0x08 clears each pending bit whose write-data bit is 1 and leaves bits written as 0 unchanged.
- R5: Sources are level-sensitive. When an input is asserted in the same cycle as a clear of its bit, the bit stays set. An input held high sets its bit again after a clear.
- R6: Among the sources that are pending, enabled and routed to an output, the source with the highest index wins that output. Source 20 is the highest and source 0 the lowest.
- R7: A pending, enabled source with routing bit 1 only takes part in the fast output. With routing bit 0 it only takes part in the normal output.
- R8: Each output is high exactly when it has at least one eligible source, and it then carries the winner's 5-bit index. When the output is low, its index is 0.
- R9: The status register (0x0C) reads the normal index in bits 4:0, the normal valid flag in bit 8, the fast index in bits 20:16 and the fast valid flag in bit 24. All other bits read 0, and writes to it have no effect.
- R10: Register bits above bit 20 read as 0. Addresses 0x10 and above read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_i | input | 21 | Level-sensitive interrupt request lines |
| addr_i | input | 6 | Byte address of the register access |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| irq_id_o | output | 5 | Index of the winning normal source |
| fiq_o | output | 1 | Fast interrupt request |
| fiq_id_o | output | 5 | Index of the winning fast source |

## Verification
The bench first raises each of the 21 sources alone, on the normal output and then on the fast output. This isolates the index encoding and the routing bit of every position. It then applies 64 pseudo-random triples of request, enable and routing words, which mix several eligible sources with disabled and cross-routed ones. These show whether the resolver prefers the highest index and whether it ignores sources that are disabled or routed to the other output. Directed sequences separate a set from a clear when both arrive in the same cycle, a disabled source that records its request from one that drops it, and clear bits written as 0 from bits written as 1.

// File: rtl/intc_pkg.sv
package intc_pkg;
   // word index of each register (byte address bits [..:2])
   localparam int unsigned REG_DIS  = 0;
   localparam int unsigned REG_ROUTE = 1;
   localparam int unsigned REG_PEND = 2;
   localparam int unsigned REG_STAT = 3;

   // status register field positions
   localparam int unsigned STAT_IRQ_ID_LSB = 0;
   localparam int unsigned STAT_IRQ_VLD    = 8;
   localparam int unsigned STAT_FIQ_ID_LSB = 16;
   localparam int unsigned STAT_FIQ_VLD    = 24;

   typedef struct packed {
      logic dis;
      logic route;
      logic pend;
      logic stat;
   } reg_sel_t;
endpackage

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs #(
   parameter int unsigned NUM_SRC = 21,
   parameter int unsigned DATA_W  = 32
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic               dis_we_i,
   input  logic               route_we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [NUM_SRC-1:0] dis_q_o,
   output logic [NUM_SRC-1:0] route_q_o
);
   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         dis_q_o   <= '1;
         route_q_o <= '0;
      end else begin
         if (dis_we_i)   dis_q_o   <= wdata_i[NUM_SRC-1:0];
         if (route_we_i) route_q_o <= wdata_i[NUM_SRC-1:0];
      end
   end
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
   parameter int unsigned NUM_SRC = 21
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic               clr_we_i,
   input  logic [NUM_SRC-1:0] clr_bits_i,
   output logic [NUM_SRC-1:0] pend_q_o
);
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
      logic clr_this;
      assign clr_this = clr_we_i & clr_bits_i[g];
      always_ff @(posedge clk_i) begin
         if (rst_i) pend_q_o[g] <= 1'b0;
         else       pend_q_o[g] <= src_i[g] | (pend_q_o[g] & ~clr_this);
      end
   end
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver #(
   parameter int unsigned NUM_SRC    = 21,
   parameter int unsigned ID_W       = 5,
   parameter bit          HIGH_FIRST = 1'b1
) (
   input  logic [NUM_SRC-1:0] req_i,
   output logic               vld_o,
   output logic [ID_W-1:0]    id_o
);
   assign vld_o = |req_i;

   if (HIGH_FIRST) begin : g_high
      always_comb begin
         id_o = '0;
         for (int i = 0; i < NUM_SRC; i++)
            if (req_i[i]) id_o = ID_W'(i);
      end
   end else begin : g_low
      always_comb begin
         id_o = '0;
         for (int i = NUM_SRC - 1; i >= 0; i--)
            if (req_i[i]) id_o = ID_W'(i);
      end
   end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
   parameter int unsigned NUM_SRC    = 21,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ADDR_W     = 6,
   parameter bit          HIGH_FIRST = 1'b1,
   localparam int unsigned ID_W      = $clog2(NUM_SRC)
) (
   input  logic               clk_i,
   input  logic               rst_i,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               we_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_o,
   output logic [ID_W-1:0]    irq_id_o,
   output logic               fiq_o,
   output logic [ID_W-1:0]    fiq_id_o
);
   import intc_pkg::*;

   localparam int unsigned WIDX_W = ADDR_W - 2;

   if (NUM_SRC < 2 || NUM_SRC >= DATA_W) begin : g_chk_src
      $error("prio_intc: NUM_SRC must lie in 2..DATA_W-1");
   end
   if (ID_W > 8) begin : g_chk_id
      $error("prio_intc: index does not fit a status field");
   end
   if (ADDR_W < 4) begin : g_chk_addr
      $error("prio_intc: ADDR_W too small for the register map");
   end
   if (DATA_W < STAT_FIQ_VLD + 1) begin : g_chk_data
      $error("prio_intc: DATA_W too small for the status layout");
   end

   logic [WIDX_W-1:0]  widx;
   reg_sel_t           sel;
   logic [NUM_SRC-1:0] dis_q, route_q, pend_q;
   logic [NUM_SRC-1:0] elig_irq, elig_fiq;
   logic [DATA_W-1:0]  stat_word;

   assign widx = addr_i[ADDR_W-1:2];

   always_comb begin
      sel       = '0;
      sel.dis   = (widx == WIDX_W'(REG_DIS));
      sel.route = (widx == WIDX_W'(REG_ROUTE));
      sel.pend  = (widx == WIDX_W'(REG_PEND));
      sel.stat  = (widx == WIDX_W'(REG_STAT));
   end

   intc_cfg_regs #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_cfg (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .dis_we_i   (we_i & sel.dis),
      .route_we_i (we_i & sel.route),
      .wdata_i    (wdata_i),
      .dis_q_o    (dis_q),
      .route_q_o  (route_q)
   );

   intc_pending #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .src_i      (src_i),
      .clr_we_i   (we_i & sel.pend),
      .clr_bits_i (wdata_i[NUM_SRC-1:0]),
      .pend_q_o   (pend_q)
   );

   assign elig_irq = pend_q & ~dis_q & ~route_q;
   assign elig_fiq = pend_q & ~dis_q &  route_q;

   intc_resolver #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .HIGH_FIRST(HIGH_FIRST)) u_res_irq (
      .req_i (elig_irq),
      .vld_o (irq_o),
      .id_o  (irq_id_o)
   );

   intc_resolver #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .HIGH_FIRST(HIGH_FIRST)) u_res_fiq (
      .req_i (elig_fiq),
      .vld_o (fiq_o),
      .id_o  (fiq_id_o)
   );

   always_comb begin
      stat_word = '0;
      stat_word[STAT_IRQ_ID_LSB +: ID_W] = irq_id_o;
      stat_word[STAT_IRQ_VLD]            = irq_o;
      stat_word[STAT_FIQ_ID_LSB +: ID_W] = fiq_id_o;
      stat_word[STAT_FIQ_VLD]            = fiq_o;
   end

   always_comb begin
      rdata_o = '0;
      unique case (1'b1)
         sel.dis:   rdata_o = DATA_W'(dis_q);
         sel.route: rdata_o = DATA_W'(route_q);
         sel.pend:  rdata_o = DATA_W'(pend_q);
         sel.stat:  rdata_o = stat_word;
         default:   rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk #(
   parameter int unsigned NUM_SRC = 21,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 6,
   parameter int unsigned ID_W    = 5
) (
   input logic               clk_i,
   input logic               rst_i,
   input logic [NUM_SRC-1:0] src_i,
   input logic [ADDR_W-1:0]  addr_i,
   input logic [DATA_W-1:0]  rdata_o,
   input logic               irq_o,
   input logic [ID_W-1:0]    irq_id_o,
   input logic               fiq_o,
   input logic [ID_W-1:0]    fiq_id_o,
   input logic [NUM_SRC-1:0] pend,
   input logic [NUM_SRC-1:0] dis,
   input logic [NUM_SRC-1:0] route
);
   localparam logic [DATA_W-1:0] VALID = {{(DATA_W-NUM_SRC){1'b0}}, {NUM_SRC{1'b1}}};

   logic seen_rst = 1'b0;
   always_ff @(posedge clk_i) seen_rst <= seen_rst | rst_i;

   logic [NUM_SRC-1:0] e_irq, e_fiq;
   assign e_irq = pend & ~dis & ~route;
   assign e_fiq = pend & ~dis &  route;

   AST_IRQ_WINNER_OK: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |-> (pend[irq_id_o] && !dis[irq_id_o] && !route[irq_id_o])); // R7
   AST_FIQ_WINNER_OK: assert property (@(posedge clk_i) disable iff (rst_i)
      fiq_o |-> (pend[fiq_id_o] && !dis[fiq_id_o] && route[fiq_id_o])); // R7
   AST_IRQ_NONE_HIGHER: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |-> (((e_irq >> irq_id_o) >> 1) == '0)); // R6
   AST_FIQ_NONE_HIGHER: assert property (@(posedge clk_i) disable iff (rst_i)
      fiq_o |-> (((e_fiq >> fiq_id_o) >> 1) == '0)); // R6
   AST_IDLE_IDS_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (!irq_o |-> irq_id_o == '0) and (!fiq_o |-> fiq_id_o == '0)); // R8
   AST_SRC_CAPTURED: assert property (@(posedge clk_i) disable iff (rst_i)
      (seen_rst && !$past(rst_i)) |-> ((pend & $past(src_i)) == $past(src_i))); // R5
   AST_NO_SPURIOUS_PEND: assert property (@(posedge clk_i) disable iff (rst_i)
      (seen_rst && !$past(rst_i)) |-> ((pend & ~$past(pend) & ~$past(src_i)) == '0)); // R3
   AST_RDATA_UPPER_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
      (addr_i[ADDR_W-1:2] < 3) |-> ((rdata_o & ~VALID) == '0)); // R10
endmodule

bind prio_intc prio_intc_chk #(
   .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .ID_W(ID_W)
) u_prio_intc_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .src_i    (src_i),
   .addr_i   (addr_i),
   .rdata_o  (rdata_o),
   .irq_o    (irq_o),
   .irq_id_o (irq_id_o),
   .fiq_o    (fiq_o),
   .fiq_id_o (fiq_id_o),
   .pend     (pend_q),
   .dis      (dis_q),
   .route    (route_q)
);

// File: tb/test_prio_intc.sv
module test_prio_intc;
   localparam int N = 21;
   localparam logic [31:0] ALL = 32'h001F_FFFF;
   localparam logic [5:0] A_DIS = 6'h00, A_RT = 6'h04, A_PND = 6'h08, A_ST = 6'h0C;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  src = '0;
   logic [5:0]    addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq, fiq;
   logic [4:0]    irq_id, fiq_id;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] lfsr = 32'h1234_5678;

   always #10 clk = ~clk;

   prio_intc i_prio_intc (
      .clk_i(clk), .rst_i(rst), .src_i(src), .addr_i(addr), .we_i(we),
      .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .irq_id_o(irq_id),
      .fiq_o(fiq), .fiq_id_o(fiq_id)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      addr = a; wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse(input logic [N-1:0] s);
      @(negedge clk);
      src = s;
      @(negedge clk);
      src = '0;
   endtask

   function automatic logic [5:0] pick(input logic [N-1:0] e);
      pick = '0;
      for (int i = 0; i < N; i++) if (e[i]) pick = {1'b1, 5'(i)};
   endfunction

   function automatic logic [31:0] stat_of(input logic [5:0] pi, input logic [5:0] pf);
      stat_of = {7'b0, pf[5], 3'b0, pf[4:0], 7'b0, pi[5], 3'b0, pi[4:0]};
   endfunction

   function automatic logic [31:0] nxt(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      nxt = y ^ (y << 5);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      rd(A_DIS, d); chk("R1 disable reset", d, ALL);
      rd(A_RT, d);  chk("R1 routing reset", d, 0);
      rd(A_PND, d); chk("R1 pending reset", d, 0);
      chk("R1 outputs reset", {30'b0, irq, fiq}, 0);

      // R2 / R10 register storage and upper bits
      wr(A_DIS, 32'hFFFF_FFFF); rd(A_DIS, d); chk("R10 disable upper bits", d, ALL);
      wr(A_DIS, 32'hA5A5_A5A5); rd(A_DIS, d); chk("R2 disable store", d, 32'hA5A5_A5A5 & ALL);
      wr(A_RT, 32'h5A5A_5A5A);  rd(A_RT, d);  chk("R2 routing store", d, 32'h5A5A_5A5A & ALL);
      wr(A_ST, 32'hFFFF_FFFF);  rd(A_ST, d);  chk("R9 status write ignored", d, 0);
      wr(6'h10, 32'h0);         rd(6'h10, d); chk("R10 unmapped read", d, 0);
      rd(A_DIS, d); chk("R10 unmapped write no effect", d, 32'hA5A5_A5A5 & ALL);
      wr(6'h3C, 32'h0);         rd(6'h3C, d); chk("R10 top unmapped read", d, 0);
      rd(A_RT, d);  chk("R10 unmapped write routing", d, 32'h5A5A_5A5A & ALL);

      // R3 disabled source still records
      wr(A_DIS, ALL); wr(A_RT, 0);
      pulse(N'(1) << 5);
      rd(A_PND, d); chk("R3 disabled records", d, 32'h20);
      chk("R3 disabled no irq", {31'b0, irq}, 0);
      wr(A_DIS, 0);
      chk("R3 enable releases irq", {26'b0, irq, irq_id}, {26'b0, 1'b1, 5'd5});
      // R4 zero write leaves bits
      wr(A_PND, 32'hFFFF_FFDF); rd(A_PND, d); chk("R4 zero bit kept", d, 32'h20);
      wr(A_PND, 32'h20);        rd(A_PND, d); chk("R4 one bit clears", d, 0);
      chk("R8 idle id zero", {26'b0, irq, irq_id}, 0);

      // R5 set wins over same-cycle clear; held level re-sets
      @(negedge clk); src = N'(1) << 7;
      @(negedge clk);
      addr = A_PND; wdata = 32'h80; we = 1'b1;
      @(negedge clk); we = 1'b0;
      rd(A_PND, d); chk("R5 set beats clear", d, 32'h80);
      wr(A_PND, 32'h80); rd(A_PND, d); chk("R5 held level re-sets", d, 32'h80);
      src = '0;
      wr(A_PND, 32'h80); rd(A_PND, d); chk("R5 cleared after release", d, 0);

      // single-source sweep: R6 R7 R8 R9
      for (int k = 0; k < N; k++) begin
         wr(A_RT, 0);
         pulse(N'(1) << k);
         rd(A_PND, d); chk("R3 single pending", d, 32'(1) << k);
         rd(A_ST, d);
         chk("R9 single irq status", d, stat_of({1'b1, 5'(k)}, 6'b0));
         chk("R8 single irq out", {26'b0, irq, irq_id}, {26'b0, 1'b1, 5'(k)});
         wr(A_RT, 32'(1) << k);
         chk("R7 single fiq out", {20'b0, irq, irq_id, fiq, fiq_id},
             {20'b0, 1'b0, 5'd0, 1'b1, 5'(k)});
         wr(A_PND, 32'(1) << k);
         rd(A_PND, d); chk("R4 single clear", d, 0);
      end

      // pseudo-random mixed patterns: R6 R7 R9
      for (int p = 0; p < 64; p++) begin
         logic [N-1:0] sv, dv, rv;
         logic [5:0] ei, ef;
         lfsr = nxt(lfsr); sv = lfsr[N-1:0];
         lfsr = nxt(lfsr); dv = lfsr[N-1:0] & lfsr[31:11];
         lfsr = nxt(lfsr); rv = lfsr[N-1:0];
         wr(A_DIS, 32'(dv)); wr(A_RT, 32'(rv));
         pulse(sv);
         ei = pick(sv & ~dv & ~rv);
         ef = pick(sv & ~dv & rv);
         chk("R6 mixed irq", {26'b0, irq, irq_id}, {26'b0, ei});
         chk("R7 mixed fiq", {26'b0, fiq, fiq_id}, {26'b0, ef});
         rd(A_ST, d); chk("R9 mixed status", d, stat_of(ei, ef));
         wr(A_PND, ALL);
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule